// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Arbiter

This block sits beside the sequencer of a small 8-bit processor core and decides, each time the core reaches an instruction boundary, whether the next thing to run is a reset entry, a non-maskable interrupt entry, a maskable interrupt entry, or the next instruction. Reset and NMI arrive as one-cycle trigger pulses and are remembered. The maskable request is a level that is sampled directly. The core also tells the arbiter whether the interrupt-disable flag is set.

A variant input picks between two behaviours. In the early variant, some instructions hold back a pending interrupt for exactly one more instruction: clearing the disable flag, pulling the status byte from the stack, and a taken branch that stays in its page. The core reports each of these with a strobe when the instruction completes. In the later variant there is never a hold-back. The chosen source is shown as a registered one-hot request. That request stays up until the core acknowledges that the entry sequence has started.

Control is a two-state machine. In `ST_WATCH` it evaluates boundaries; the transition *grant* (a boundary that selects a source) moves it to `ST_GRANT`. There it holds the request, and the transition *release* (acknowledge) returns it to `ST_WATCH`. A boundary that selects nothing, or that is skipped by a hold-back, stays in `ST_WATCH`.

Top module: `intr_boundary_arbiter`

## Requirements
- R1: `svc_req` is one-hot or zero: bit 0 is reset, bit 1 is NMI, bit 2 is IRQ. The value is registered and appears on the clock edge that samples the boundary.
- R2: At a boundary, priority is reset, then NMI, then IRQ. IRQ is granted only when `dis_flag` is 0 at that boundary.
- R3: A reset or NMI trigger pulse is latched. It stays pending across any number of cycles and boundaries until a request of that kind is acknowledged. IRQ has no latch: a pulse on `irq_line` that has ended before the boundary produces nothing.
- R4: Once raised, `svc_req` holds its value, and further boundaries are ignored, until `svc_ack` is high. The cycle after the acknowledge, `svc_req` is 0.
- R5: A pending reset is granted at the first boundary, whatever delay flags are armed.
- R6: Early variant: a completed flag-clear instruction arms the IRQ hold-back when `was_dis` (the disable flag before it) was 1. With `was_dis` 0 it arms nothing, so repeated clears delay only once.
- R7: Early variant: a completed status pull arms the IRQ hold-back only when `was_dis` is 1 and `dis_flag` after the pull is 0.
- R8: Early variant: a same-page taken branch arms both the IRQ and the NMI hold-back.
- R9: A boundary is skipped once when something is pending, no reset is pending, and either the NMI hold-back is armed, or the IRQ hold-back is armed with no NMI pending. A boundary that follows a skip is never skipped. A boundary with nothing pending consumes no skip.
- R10: Every boundary evaluated in `ST_WATCH` disarms both hold-backs, so an arming is lost if the boundary after it has nothing pending.
- R11: With `late_variant` high, the completion strobes have no effect and no boundary is ever skipped.
- R12: After `rst_n` is released, `svc_req` is 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the arbiter itself |
| rst_trig | input | 1 | One-cycle core reset request pulse |
| nmi_trig | input | 1 | One-cycle NMI event pulse |
| irq_line | input | 1 | Maskable interrupt level, active high |
| dis_flag | input | 1 | Current interrupt-disable flag |
| was_dis | input | 1 | Disable flag before the instruction being reported |
| fin_clear | input | 1 | Flag-clear instruction completed |
| fin_pull | input | 1 | Status pull completed |
| fin_branch | input | 1 | Same-page taken branch completed |
| boundary | input | 1 | Core is at an instruction boundary |
| late_variant | input | 1 | 1 selects the later variant (no hold-back) |
| svc_ack | input | 1 | Core has started the granted entry sequence |
| svc_req | output | 3 | One-hot service request {IRQ, NMI, reset} |

## Verification
A hold-back flag stuck armed shows as a missing request at the very boundary where one was due. A hold-back flag that fails to arm shows as a request one boundary early. In both cases the error is visible at the port on the edge after that boundary. A stale "already skipped" flag shows up as a second consecutive skip, and so as a request that arrives two boundaries late. A lost NMI or reset latch shows as nothing granted at a boundary after a pulse that was never acknowledged. The sequences in the bench are arranged so that each of these faults changes `svc_req` within one boundary.

// File: rtl/intarb_pkg.sv
package intarb_pkg;
    localparam int NSRC    = 3;
    localparam int SRC_RST = 0;
    localparam int SRC_NMI = 1;
    localparam int SRC_IRQ = 2;
    localparam int NLATCH  = 2;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic {
        ST_WATCH = 1'b0,
        ST_GRANT = 1'b1
    } arb_state_t;
endpackage

// File: rtl/intarb_pulse_latch.sv
module intarb_pulse_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= trig | (pend & ~clr);
    end

    // R3: a pending event is held until it is serviced
    a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !clr |=> pend);
    a_r3_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pend);
endmodule

// File: rtl/intarb_delay.sv
module intarb_delay (
    input  logic clk,
    input  logic rst_n,
    input  logic late_variant,
    input  logic fin_clear,
    input  logic fin_pull,
    input  logic fin_branch,
    input  logic was_dis,
    input  logic dis_flag,
    input  logic bnd_clr,
    input  logic consult,
    input  logic rst_pend,
    input  logic nmi_pend,
    output logic skip
);
    logic idly, ndly, handled;
    logic arm_i, arm_n;

    always_comb begin
        arm_i = 1'b0;
        arm_n = 1'b0;
        if (!late_variant) begin
            if (fin_clear)  arm_i = was_dis;
            if (fin_pull)   arm_i = was_dis & ~dis_flag;
            if (fin_branch) begin
                arm_i = 1'b1;
                arm_n = 1'b1;
            end
        end
    end

    assign skip = consult & ~late_variant & ~rst_pend & ~handled &
                  (ndly | (idly & ~nmi_pend));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idly    <= 1'b0;
            ndly    <= 1'b0;
            handled <= 1'b0;
        end else begin
            if (bnd_clr) begin
                idly <= 1'b0;
                ndly <= 1'b0;
            end
            if (arm_i) idly <= 1'b1;
            if (arm_n) ndly <= 1'b1;
            if (consult) handled <= skip;
        end
    end

    // R11: the later variant never skips
    a_r11_no_skip_late: assert property (@(posedge clk) disable iff (!rst_n)
        late_variant |-> !skip);
    // R10: a boundary with no new arming leaves both hold-backs clear
    a_r10_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_clr && !fin_clear && !fin_pull && !fin_branch |=> !idly && !ndly);
    // R9: two consecutive evaluated boundaries are never both skipped
    a_r9_single_skip: assert property (@(posedge clk) disable iff (!rst_n)
        skip |=> !skip);
endmodule

// File: rtl/intarb_fsm.sv
module intarb_fsm
    import intarb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                boundary,
    input  logic                rst_pend,
    input  logic                nmi_pend,
    input  logic                irq_line,
    input  logic                dis_flag,
    input  logic                skip,
    input  logic                svc_ack,
    output logic                consult,
    output logic                bnd_clr,
    output logic [NLATCH-1:0]   clr_vec,
    output src_vec_t            svc_req
);
    arb_state_t state, state_nx;
    src_vec_t   pick;

    assign bnd_clr = boundary && (state == ST_WATCH);
    assign consult = bnd_clr && (rst_pend || nmi_pend || irq_line);

    always_comb begin
        pick = '0;
        if (rst_pend)                  pick[SRC_RST] = 1'b1;
        else if (skip)                 pick = '0;
        else if (nmi_pend)             pick[SRC_NMI] = 1'b1;
        else if (irq_line && !dis_flag) pick[SRC_IRQ] = 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WATCH: if (consult && (pick != '0)) state_nx = ST_GRANT;
            ST_GRANT: if (svc_ack)                 state_nx = ST_WATCH;
            default:                               state_nx = ST_WATCH;
        endcase
    end

    always_comb begin
        clr_vec = '0;
        if (state == ST_GRANT && svc_ack) clr_vec = svc_req[NLATCH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WATCH;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_req <= '0;
        end else begin
            unique case (state)
                ST_WATCH: if (consult) svc_req <= pick;
                ST_GRANT: if (svc_ack) svc_req <= '0;
                default:               svc_req <= '0;
            endcase
        end
    end

    // R1: at most one source requested
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_req));
    // R4: request held until acknowledged
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_GRANT && !svc_ack |=> $stable(svc_req));
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_GRANT && svc_ack |=> svc_req == '0);
    // R5: reset wins at once
    a_r5_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        consult && rst_pend |=> svc_req == src_vec_t'(1 << SRC_RST));
    // R2: IRQ only when unmasked
    a_r2_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_req[SRC_IRQ]) |-> $past(!dis_flag));
endmodule

// File: rtl/intr_boundary_arbiter.sv
module intr_boundary_arbiter
    import intarb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_trig,
    input  logic            nmi_trig,
    input  logic            irq_line,
    input  logic            dis_flag,
    input  logic            was_dis,
    input  logic            fin_clear,
    input  logic            fin_pull,
    input  logic            fin_branch,
    input  logic            boundary,
    input  logic            late_variant,
    input  logic            svc_ack,
    output logic [NSRC-1:0] svc_req
);
    logic [NLATCH-1:0] trig_vec, clr_vec, pend_vec;
    logic consult, bnd_clr, skip;

    assign trig_vec[SRC_RST] = rst_trig;
    assign trig_vec[SRC_NMI] = nmi_trig;

    for (genvar g = 0; g < NLATCH; g++) begin : g_latch
        intarb_pulse_latch u_latch (
            .clk  (clk),
            .rst_n(rst_n),
            .trig (trig_vec[g]),
            .clr  (clr_vec[g]),
            .pend (pend_vec[g])
        );
    end

    intarb_delay u_delay (
        .clk         (clk),
        .rst_n       (rst_n),
        .late_variant(late_variant),
        .fin_clear   (fin_clear),
        .fin_pull    (fin_pull),
        .fin_branch  (fin_branch),
        .was_dis     (was_dis),
        .dis_flag    (dis_flag),
        .bnd_clr     (bnd_clr),
        .consult     (consult),
        .rst_pend    (pend_vec[SRC_RST]),
        .nmi_pend    (pend_vec[SRC_NMI]),
        .skip        (skip)
    );

    intarb_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .boundary(boundary),
        .rst_pend(pend_vec[SRC_RST]),
        .nmi_pend(pend_vec[SRC_NMI]),
        .irq_line(irq_line),
        .dis_flag(dis_flag),
        .skip    (skip),
        .svc_ack (svc_ack),
        .consult (consult),
        .bnd_clr (bnd_clr),
        .clr_vec (clr_vec),
        .svc_req (svc_req)
    );
endmodule

// File: tb/intr_boundary_arbiter_tb.sv
module intr_boundary_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;
    // kind[13:12] 0 none 1 clear 2 pull 3 branch | ib | ia | nmi | irq | db | late | exp1[5:3] | exp2[2:0]
    localparam logic [13:0] VEC [NV] = '{
        {2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd4,3'd0},
        {2'd1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,3'd4},
        {2'd1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,3'd4,3'd0},
        {2'd1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd4,3'd0},
        {2'd2,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,3'd4},
        {2'd2,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd4,3'd0},
        {2'd2,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,3'd0,3'd0},
        {2'd3,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,3'd2},
        {2'd3,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,3'd2,3'd0},
        {2'd1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'd2,3'd4},
        {2'd1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,3'd0,3'd0},
        {2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,3'd2,3'd4},
        {2'd3,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,3'd4}
    };
    string vtag [NV] = '{"R2","R6","R11","R6","R7","R7","R7","R8","R11","R9","R6","R2","R8"};

    logic clk = 1'b0, rst_n = 1'b0;
    logic rst_trig = 0, nmi_trig = 0, irq_line = 0, dis_flag = 0, was_dis = 0;
    logic fin_clear = 0, fin_pull = 0, fin_branch = 0, boundary = 0;
    logic late_variant = 0, svc_ack = 0;
    logic [2:0] svc_req;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_boundary_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .rst_trig(rst_trig), .nmi_trig(nmi_trig),
        .irq_line(irq_line), .dis_flag(dis_flag), .was_dis(was_dis),
        .fin_clear(fin_clear), .fin_pull(fin_pull), .fin_branch(fin_branch),
        .boundary(boundary), .late_variant(late_variant), .svc_ack(svc_ack),
        .svc_req(svc_req)
    );

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(string tag, logic [2:0] exp);
        n_chk++;
        if (svc_req !== exp) begin
            n_bad++;
            $display("FAIL %s: svc_req=%b expected %b at %0t", tag, svc_req, exp, $time);
        end
    endtask

    task automatic bnd();
        boundary = 1; step(); boundary = 0;
    endtask

    task automatic ack();
        if (svc_req[2]) irq_line = 0;
        svc_ack = 1; step(); svc_ack = 0;
    endtask

    task automatic strobe(int kind, logic ib, logic ia);
        was_dis = ib; dis_flag = ia;
        fin_clear = (kind == 1); fin_pull = (kind == 2); fin_branch = (kind == 3);
        step();
        fin_clear = 0; fin_pull = 0; fin_branch = 0;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); cyc++;
            if (cyc > 20000) begin
                n_bad++; n_chk++;
                $display("FAIL watchdog: actual hang expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        step(); step();
        chk("R12 in reset", 3'd0);
        rst_n = 1; step();
        chk("R12 after reset", 3'd0);

        for (int i = 0; i < NV; i++) begin
            logic [13:0] v;
            v = VEC[i];
            late_variant = v[6];
            if (v[13:12] != 2'd0) strobe(int'(v[13:12]), v[11], v[10]);
            dis_flag = v[10];
            irq_line = v[8];
            if (v[9]) begin nmi_trig = 1; step(); nmi_trig = 0; end
            bnd();
            chk({vtag[i], " first boundary"}, v[5:3]);
            if (svc_req != 0) ack();
            dis_flag = v[7];
            bnd();
            chk({vtag[i], " second boundary"}, v[2:0]);
            if (svc_req != 0) ack();
            irq_line = 0; late_variant = 0; dis_flag = 0;
            step();
        end

        // R5: reset ignores the armed hold-back and outranks NMI
        strobe(3, 0, 0);
        rst_trig = 1; nmi_trig = 1; step(); rst_trig = 0; nmi_trig = 0;
        bnd(); chk("R5 reset first", 3'b001);
        ack(); chk("R4 cleared after ack", 3'b000);
        bnd(); chk("R2 NMI after reset", 3'b010);

        // R4: held through boundaries without acknowledge
        irq_line = 1; bnd(); bnd();
        chk("R4 held", 3'b010);
        ack(); chk("R4 released", 3'b000);
        bnd(); chk("R2 IRQ after NMI", 3'b100);
        ack();

        // R3: NMI stays latched for many idle cycles; IRQ is not latched
        nmi_trig = 1; step(); nmi_trig = 0;
        for (int k = 0; k < 6; k++) step();
        bnd(); chk("R3 NMI latched", 3'b010);
        ack();
        irq_line = 1; step(); irq_line = 0; step();
        bnd(); chk("R3 IRQ pulse not kept", 3'b000);

        // R9: a second armed branch right after a skip is not skipped
        strobe(3, 0, 0);
        nmi_trig = 1; step(); nmi_trig = 0;
        bnd(); chk("R9 first skip", 3'b000);
        strobe(3, 0, 0);
        bnd(); chk("R9 no second skip", 3'b010);
        ack();

        // R9/R10: boundary with nothing pending disarms, consumes nothing
        strobe(3, 0, 0);
        bnd(); chk("R10 idle boundary", 3'b000);
        nmi_trig = 1; step(); nmi_trig = 0;
        bnd(); chk("R10 hold-back dropped", 3'b010);
        ack();
        strobe(1, 1, 0);
        bnd();
        irq_line = 1;
        bnd(); chk("R10 clear arming dropped", 3'b100);
        ack();

        // R11: late variant ignores a pull strobe as well
        late_variant = 1;
        strobe(2, 1, 0);
        irq_line = 1;
        bnd(); chk("R11 pull ignored", 3'b100);
        ack(); late_variant = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule